// File: doc/BRIEF.md
# Video DMA Cycle-Steal Scheduler

This block decides, for every CPU cycle of a scanline, whether the video controller takes the memory bus for a DMA fetch or leaves the bus to the CPU. A CPU cycle spans two color clocks, and a line holds 228 color clocks, which is 114 CPU cycles. Each fetch kind has a fixed color-clock slot in the line. Display-list bytes come first. Sprite and missile data follow. Playfield fetches are placed by the selected width and by the mode class. DRAM refresh takes whichever of its candidate slots are still free.

Each clock, the block receives the current color-clock position, the scanline number, the DMA enables, the mode class, the width selection and a flag that marks the first line of a mode row. One clock later it presents a CPU halt and a fetch-kind code. Address generation and display-list decoding belong to neighbouring logic.

Top module: `vdma_sched`

## Requirements
- R1: A fetch occupies exactly one slot. halt_o is high exactly when fetch_o is nonzero. fetch_o codes: 0 idle, 1 display list, 2 sprite, 3 missile, 4 character code, 5 playfield data, 6 refresh. Only even color clocks below 228 carry a fetch.
- R2: On display lines where row_first_i and dl_en_i are both high, a display-list byte is fetched at color clock 0. Two more are fetched at color clocks 10 and 12 when dl_ext_i is also high.
- R3: When player_en_i is high, sprite data is fetched at color clocks 2, 4, 6 and 8 on every scanline, inside or outside the display window and on first or later row lines.
- R4: A missile byte is fetched at color clock 226 on every scanline when missile_en_i or player_en_i is high.
- R5: Playfield fetches happen only on display lines, vpos_i in [8,248), with pf_en_i high. width_i selects the window: 0 narrow (starts at clock 64, 32 bytes), 1 normal (starts at 48, 40 bytes), 2 or 3 wide (starts at 32, 48 bytes).
- R6: mode_i 0 or 3 is graphics. Data is fetched at start+4k on the first row line only, and later lines fetch nothing.
- R7: mode_i 1 is text, which uses half the bytes at a pitch of 8. The character code is fetched at start+8k on the first line only. Glyph data is fetched at start+8k+2 on every line of the row.
- R8: mode_i 2 is hires text. The character code is fetched at start+4k on the first line only. Glyph data is fetched at start+4k+2 on every line of the row.
- R9: The refresh candidates are color clocks 86+16k for k=0..8. A candidate is used only when no other fetch holds the slot. This gives 9 refreshes per line, except on hires-text display lines with the playfield on, where the counts are 1 for normal width, 2 for narrow width and 0 for wide width.
- R10: When two fetches claim the same slot, the winner follows this priority order: display list, then sprite/missile, then playfield, then refresh.
- R11: Outputs are registered and show the inputs of the previous clock. Under reset, fetch_o and halt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one color clock per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpos_i | input | 8 | Color-clock position in line |
| vpos_i | input | 9 | Scanline number |
| dl_en_i | input | 1 | Display-list DMA enable |
| dl_ext_i | input | 1 | Current instruction carries two operand bytes |
| player_en_i | input | 1 | Sprite DMA enable (forces missile DMA) |
| missile_en_i | input | 1 | Missile DMA enable |
| pf_en_i | input | 1 | Playfield DMA enable |
| mode_i | input | 2 | Mode class: 0 graphics, 1 text, 2 hires text, 3 graphics |
| width_i | input | 2 | Playfield width: 0 narrow, 1 normal, 2/3 wide |
| row_first_i | input | 1 | First line of a mode row |
| halt_o | output | 1 | CPU halted this cycle |
| fetch_o | output | 3 | Fetch kind code |

## Verification
The bench sweeps every color-clock position through whole lines for all three mode classes and all three widths, on both first and later row lines. This separates what is fetched once per row from what is fetched on every line, and it measures the refresh count that each combination leaves. Further lines turn the playfield off, run in vertical blank and split the sprite and missile enables. These show that sprite, missile and refresh fetches do not depend on the display window, and that enabling sprites alone still produces the missile fetch. A second instance moves the playfield start and the refresh candidates onto the display-list and sprite slots, so that the priority order between fetch kinds can be observed.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [2:0] {
    FT_NONE    = 3'd0,
    FT_DLIST   = 3'd1,
    FT_PLAYER  = 3'd2,
    FT_MISSILE = 3'd3,
    FT_CHAR    = 3'd4,
    FT_PFDATA  = 3'd5,
    FT_REFRESH = 3'd6
  } fetch_e;

  localparam logic [1:0] MC_TEXT  = 2'd1;
  localparam logic [1:0] MC_HIRES = 2'd2;

  localparam logic [1:0] WS_NARROW = 2'd0;
  localparam logic [1:0] WS_NORMAL = 2'd1;

  localparam logic [7:0] DL_SLOT0 = 8'd0;
  localparam logic [7:0] DL_SLOT1 = 8'd10;
  localparam logic [7:0] DL_SLOT2 = 8'd12;
  localparam logic [7:0] PL_FIRST = 8'd2;
  localparam logic [7:0] PL_LAST  = 8'd8;
endpackage

// File: rtl/vdma_fixed_slots.sv
module vdma_fixed_slots
  import vdma_pkg::*;
#(
  parameter int MISSILE_CCLK = 226
) (
  input  logic [7:0] hpos_i,
  input  logic       disp_i,
  input  logic       dl_en_i,
  input  logic       dl_ext_i,
  input  logic       row_first_i,
  input  logic       player_en_i,
  input  logic       missile_en_i,
  output logic       dl_hit_o,
  output logic       player_hit_o,
  output logic       missile_hit_o
);
  logic dl_slot, op_slot;

  assign dl_slot = (hpos_i == DL_SLOT0);
  assign op_slot = (hpos_i == DL_SLOT1) || (hpos_i == DL_SLOT2);

  assign dl_hit_o = dl_en_i && disp_i && row_first_i && (dl_slot || (dl_ext_i && op_slot));

  assign player_hit_o = player_en_i && (hpos_i >= PL_FIRST) && (hpos_i <= PL_LAST)
                        && !hpos_i[0];

  // sprite DMA drags missile DMA along
  assign missile_hit_o = (missile_en_i || player_en_i) && (hpos_i == 8'(MISSILE_CCLK));
endmodule

// File: rtl/vdma_pf_slots.sv
module vdma_pf_slots
  import vdma_pkg::*;
#(
  parameter int NARROW_START = 64,
  parameter int NORMAL_START = 48,
  parameter int WIDE_START   = 32,
  parameter int NARROW_BYTES = 32,
  parameter int NORMAL_BYTES = 40,
  parameter int WIDE_BYTES   = 48
) (
  input  logic [7:0] hpos_i,
  input  logic       active_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] width_i,
  input  logic       row_first_i,
  output logic       char_hit_o,
  output logic       data_hit_o
);
  localparam int AW = 10;

  logic [AW-1:0] start, bytes, off, idx, limit;
  logic          in_win, ok, is_text, is_hires;
  logic [2:0]    phase;

  always_comb begin
    case (width_i)
      WS_NARROW: begin start = AW'(NARROW_START); bytes = AW'(NARROW_BYTES); end
      WS_NORMAL: begin start = AW'(NORMAL_START); bytes = AW'(NORMAL_BYTES); end
      default:   begin start = AW'(WIDE_START);   bytes = AW'(WIDE_BYTES);   end
    endcase
    is_text  = (mode_i == MC_TEXT);
    is_hires = (mode_i == MC_HIRES);
    in_win   = ({2'b00, hpos_i} >= start);
    off      = {2'b00, hpos_i} - start;
    // text rows run half the bytes at double pitch
    idx      = is_text ? (off >> 3) : (off >> 2);
    limit    = is_text ? (bytes >> 1) : bytes;
    phase    = is_text ? off[2:0] : {1'b0, off[1:0]};
    ok       = active_i && in_win && (idx < limit);

    char_hit_o = 1'b0;
    data_hit_o = 1'b0;
    if (ok) begin
      if (is_text || is_hires) begin
        char_hit_o = (phase == 3'd0) && row_first_i;
        data_hit_o = (phase == 3'd2);
      end else begin
        data_hit_o = (phase == 3'd0) && row_first_i;
      end
    end
  end
endmodule

// File: rtl/vdma_ref_slots.sv
module vdma_ref_slots #(
  parameter int REF_START = 86,
  parameter int REF_STEP  = 16,
  parameter int REF_COUNT = 9
) (
  input  logic [7:0] hpos_i,
  output logic       ref_hit_o
);
  logic [REF_COUNT-1:0] hit;

  for (genvar k = 0; k < REF_COUNT; k++) begin : g_ref
    assign hit[k] = ({2'b00, hpos_i} == 10'(REF_START + k * REF_STEP));
  end

  assign ref_hit_o = |hit;
endmodule

// File: rtl/vdma_sched.sv
module vdma_sched
  import vdma_pkg::*;
#(
  parameter int LINE_CCLK    = 228,
  parameter int DISP_FIRST   = 8,
  parameter int DISP_END     = 248,
  parameter int MISSILE_CCLK = 226,
  parameter int NARROW_START = 64,
  parameter int NORMAL_START = 48,
  parameter int WIDE_START   = 32,
  parameter int NARROW_BYTES = 32,
  parameter int NORMAL_BYTES = 40,
  parameter int WIDE_BYTES   = 48,
  parameter int REF_START    = 86,
  parameter int REF_STEP     = 16,
  parameter int REF_COUNT    = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] hpos_i,
  input  logic [8:0] vpos_i,
  input  logic       dl_en_i,
  input  logic       dl_ext_i,
  input  logic       player_en_i,
  input  logic       missile_en_i,
  input  logic       pf_en_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] width_i,
  input  logic       row_first_i,
  output logic       halt_o,
  output logic [2:0] fetch_o
);
  logic   disp, slot_ok;
  logic   dl_hit, player_hit, missile_hit, char_hit, data_hit, ref_hit;
  fetch_e fetch_d, fetch_q;
  logic   halt_d, halt_q, past_ok_q;

  assign disp    = (vpos_i >= 9'(DISP_FIRST)) && (vpos_i < 9'(DISP_END));
  assign slot_ok = !hpos_i[0] && (hpos_i < 8'(LINE_CCLK));

  vdma_fixed_slots #(.MISSILE_CCLK(MISSILE_CCLK)) fixed_i (
    .hpos_i       (hpos_i),
    .disp_i       (disp),
    .dl_en_i      (dl_en_i),
    .dl_ext_i     (dl_ext_i),
    .row_first_i  (row_first_i),
    .player_en_i  (player_en_i),
    .missile_en_i (missile_en_i),
    .dl_hit_o     (dl_hit),
    .player_hit_o (player_hit),
    .missile_hit_o(missile_hit)
  );

  vdma_pf_slots #(
    .NARROW_START(NARROW_START), .NORMAL_START(NORMAL_START), .WIDE_START(WIDE_START),
    .NARROW_BYTES(NARROW_BYTES), .NORMAL_BYTES(NORMAL_BYTES), .WIDE_BYTES(WIDE_BYTES)
  ) pf_i (
    .hpos_i     (hpos_i),
    .active_i   (pf_en_i && disp),
    .mode_i     (mode_i),
    .width_i    (width_i),
    .row_first_i(row_first_i),
    .char_hit_o (char_hit),
    .data_hit_o (data_hit)
  );

  vdma_ref_slots #(.REF_START(REF_START), .REF_STEP(REF_STEP), .REF_COUNT(REF_COUNT)) ref_i (
    .hpos_i   (hpos_i),
    .ref_hit_o(ref_hit)
  );

  // fixed priority: display list, sprite/missile, playfield, refresh
  always_comb begin
    fetch_d = FT_NONE;
    if (slot_ok) begin
      if      (dl_hit)      fetch_d = FT_DLIST;
      else if (player_hit)  fetch_d = FT_PLAYER;
      else if (missile_hit) fetch_d = FT_MISSILE;
      else if (char_hit)    fetch_d = FT_CHAR;
      else if (data_hit)    fetch_d = FT_PFDATA;
      else if (ref_hit)     fetch_d = FT_REFRESH;
    end
    halt_d = slot_ok && (dl_hit || player_hit || missile_hit || char_hit || data_hit || ref_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q   <= FT_NONE;
      halt_q    <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      fetch_q   <= fetch_d;
      halt_q    <= halt_d;
      past_ok_q <= 1'b1;
    end
  end

  assign fetch_o = fetch_q;
  assign halt_o  = halt_q;

  assert_halt_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o == (fetch_o != 3'd0));

  assert_odd_slot_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(hpos_i[0])) |-> (fetch_o == 3'd0));

  assert_dl_first_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(hpos_i == 8'd0 && dl_en_i && row_first_i && disp))
      |-> (fetch_o == 3'd1));

  assert_missile_forced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(player_en_i && hpos_i == 8'(MISSILE_CCLK)))
      |-> (fetch_o == 3'd3));

  assert_gfx_later_line_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(!row_first_i && (mode_i == 2'd0 || mode_i == 2'd3)))
      |-> (fetch_o != 3'd4 && fetch_o != 3'd5));

  assert_no_dl_outside_display_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(!disp)) |-> (fetch_o != 3'd1 && fetch_o != 3'd4 && fetch_o != 3'd5));
endmodule

// File: tb/vdma_sched_tb_top.sv
module vdma_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hpos = '0;
  logic [8:0] vpos = '0;
  logic       dl_en = 0, dl_ext = 0, pl_en = 0, mi_en = 0, pf_en = 0, first = 0;
  logic [1:0] mode = '0, width = '0;
  logic       halt_a, halt_b;
  logic [2:0] fetch_a, fetch_b;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  vdma_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hpos_i(hpos), .vpos_i(vpos),
    .dl_en_i(dl_en), .dl_ext_i(dl_ext), .player_en_i(pl_en), .missile_en_i(mi_en),
    .pf_en_i(pf_en), .mode_i(mode), .width_i(width), .row_first_i(first),
    .halt_o(halt_a), .fetch_o(fetch_a)
  );

  // shifted layout so that fetch kinds collide (R10)
  vdma_sched #(.NORMAL_START(8), .REF_START(0), .REF_STEP(2)) dut_prio_i (
    .clk_i(clk), .rst_ni(rst_n), .hpos_i(hpos), .vpos_i(vpos),
    .dl_en_i(dl_en), .dl_ext_i(dl_ext), .player_en_i(pl_en), .missile_en_i(mi_en),
    .pf_en_i(pf_en), .mode_i(mode), .width_i(width), .row_first_i(first),
    .halt_o(halt_b), .fetch_o(fetch_b)
  );

  function automatic int exp_fetch(int h, int nstart, int rstart, int rstep);
    bit disp = (vpos >= 8) && (vpos < 248);
    int start, nbytes, pitch, r;
    if ((h % 2) != 0 || h >= 228) return 0;
    if (dl_en && disp && first && (h == 0 || (dl_ext && (h == 10 || h == 12)))) return 1;
    if (pl_en && h >= 2 && h <= 8) return 2;
    if ((pl_en || mi_en) && h == 226) return 3;
    if (pf_en && disp) begin
      case (width)
        2'd0:    begin start = 64;     nbytes = 32; end
        2'd1:    begin start = nstart; nbytes = 40; end
        default: begin start = 32;     nbytes = 48; end
      endcase
      pitch = (mode == 2'd1) ? 8 : 4;
      if (mode == 2'd1) nbytes = nbytes / 2;
      if (h >= start && h < start + pitch * nbytes) begin
        r = (h - start) % pitch;
        if (mode == 2'd1 || mode == 2'd2) begin
          if (r == 0 && first) return 4;
          if (r == 2) return 5;
        end else if (r == 0 && first) return 5;
      end
    end
    if (h >= rstart && ((h - rstart) % rstep) == 0 && ((h - rstart) / rstep) < 9) return 6;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (h=%0d v=%0d mode=%0d width=%0d first=%0d)",
               req, what, act, exp, hpos, vpos, mode, width, first);
    end
  endtask

  // one full line; outputs are registered, so sample just after the capturing edge (R11)
  task automatic run_line(string req);
    int refs = 0, exp_refs;
    int ea, eb;
    for (int h = 0; h < 228; h++) begin
      @(negedge clk);
      hpos = 8'(h);
      @(posedge clk);
      #1;
      ea = exp_fetch(h, 48, 86, 16);
      eb = exp_fetch(h, 8, 0, 2);
      check(req, int'(fetch_a), ea, "fetch");
      check("R1", int'(halt_a), (ea != 0) ? 1 : 0, "halt");
      check("R10", int'(fetch_b), eb, "prio fetch");
      if (fetch_a == 3'd6) refs++;
    end
    // R9 refresh budget per line
    exp_refs = 9;
    if (pf_en && vpos >= 8 && vpos < 248 && mode == 2'd2)
      exp_refs = (width == 2'd0) ? 2 : (width == 2'd1) ? 1 : 0;
    check("R9", refs, exp_refs, "refresh count");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11", int'(fetch_a), 0, "reset fetch");
    check("R11", int'(halt_a), 0, "reset halt");
    @(negedge clk);
    rst_n = 1'b1;

    // R5 R6 R7 R8 R2: every mode class, width and row position on a display line
    vpos = 9'd20; dl_en = 1; dl_ext = 1; pl_en = 1; mi_en = 0; pf_en = 1;
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++)
        for (int f = 0; f < 2; f++) begin
          mode = 2'(m); width = 2'(w); first = f[0];
          run_line("R5");
        end

    // R9: playfield off on hires line keeps all refreshes
    pf_en = 0; mode = 2'd2; width = 2'd1; first = 1;
    run_line("R9");

    // R3 R4: vertical blank still gets sprite/missile/refresh, no DL or playfield
    pf_en = 1; vpos = 9'd250;
    run_line("R3");

    // R4: missile alone; R2: no operand bytes
    vpos = 9'd100; pl_en = 0; mi_en = 1; dl_ext = 0; mode = 2'd1; width = 2'd0;
    run_line("R4");

    // R2: later row line skips display list; sprites alone on a later line
    pl_en = 1; mi_en = 0; first = 0; dl_ext = 1;
    run_line("R2");

    // R5: window edge lines
    first = 1; vpos = 9'd7;   run_line("R5");
    vpos = 9'd8;   run_line("R5");
    vpos = 9'd247; run_line("R5");
    vpos = 9'd248; run_line("R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule